// File: doc/BRIEF.md
# RAID-5 Small-Write Parity Engine

This block sits between a logical block interface and a five-column disk array whose parity block moves to a different column on every stripe. A logical block number is turned into a stripe number, a data column and a parity column. A logical write of one block is carried out as a read-modify-write. The engine fetches the old contents of the target data block and of the stripe's parity block. It then stores the new data and a refreshed parity word, which is the bitwise XOR of old data, new data and old parity. A logical read is served by one physical read of the mapped data column.

Only one logical request is handled at a time. A busy output holds off the requester, and a one-cycle done pulse marks completion. The disk side is a simple issue/response port. The engine raises one request, then waits for the matching response before it raises the next, so at most one disk operation is outstanding.

Top module: `raid5_rmw_engine`

## Requirements
- R1: The stripe number presented on `dreq_stripe` for every disk operation equals the logical block number divided by 4 (integer division); the data slot within the stripe is the block number modulo 4.
- R2: The parity column of stripe s is 4 − (s mod 5): stripe 0 uses disk 4, stripe 4 uses disk 0, stripe 5 uses disk 4 again.
- R3: The data column is the slot number when the slot is below the parity column, and the slot number plus one otherwise; it is never the parity column.
- R4: A logical write produces exactly four disk operations, in this order: read data column, read parity column, write data column, write parity column (`dreq_write` 0 for reads, 1 for writes). No write is issued before both reads have been answered.
- R5: The data-column write carries the new data, and the parity-column write carries old data XOR new data XOR old parity, so every stripe keeps an XOR of zero across its five blocks.
- R6: A logical read produces exactly one disk read, of the mapped data column and never of the parity column, and `rd_data` holds the returned word while `done` is high.
- R7: `done` is high for exactly one cycle, the cycle after the response to the last disk operation of the request is sampled.
- R8: `busy` rises in the cycle after a request is accepted, stays high through the `done` cycle and falls in the next cycle; `req_valid` while `busy` is high is ignored and produces no disk traffic.
- R9: `dreq_valid` is a one-cycle pulse; the first one follows acceptance by one cycle, each later one follows the previous response by one cycle, and none is raised while a response is still awaited.
- R10: While reset is asserted, `busy`, `done` and `dreq_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Logical request present; taken when `busy` is low |
| req_write | input | 1 | 1 = logical write, 0 = logical read |
| req_lba | input | LBA_W (16) | Logical block number |
| req_wdata | input | DATA_W (32) | New block contents for a write |
| busy | output | 1 | Request in progress; new requests are ignored |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W (32) | Result of a logical read, valid with `done` |
| dreq_valid | output | 1 | Disk operation issue pulse |
| dreq_write | output | 1 | 1 = disk write, 0 = disk read |
| dreq_disk | output | 3 | Disk column index (0..4) |
| dreq_stripe | output | LBA_W (16) | Block address on the selected disk (stripe number) |
| dreq_wdata | output | DATA_W (32) | Word to store for a disk write |
| dresp_valid | input | 1 | Response to the outstanding disk operation |
| dresp_rdata | input | DATA_W (32) | Returned word for a disk read |

## Verification
Every result of this block lands a fixed number of cycles after the event that causes it. The first disk operation appears one cycle after acceptance, each later operation one cycle after the previous response, `done` one cycle after the final response, and `busy` falls one cycle after `done`. The bench's behavioural model advances on each falling edge, and from the acceptance and response events it has seen it derives which of these outputs must be active in that cycle. Every output is compared in every cycle, and the disk responder varies its latency from one to three cycles, so these timing rules are tested across different gaps.

// File: rtl/raid5_rmw_pkg.sv
package raid5_rmw_pkg;

   // sequencing states of the small-write engine
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_DAT,
      ST_WT_RD_DAT,
      ST_RD_PAR,
      ST_WT_RD_PAR,
      ST_WR_DAT,
      ST_WT_WR_DAT,
      ST_WR_PAR,
      ST_WT_WR_PAR,
      ST_DONE
   } eng_state_t;

   function automatic bit is_issue_state(eng_state_t s);
      return (s == ST_RD_DAT) || (s == ST_RD_PAR) || (s == ST_WR_DAT) || (s == ST_WR_PAR);
   endfunction

endpackage

// File: rtl/raid5_rmw_map.sv
module raid5_rmw_map #(
   parameter int NDISK = 5,
   parameter int LBA_W = 16
) (
   input  logic [LBA_W-1:0]         lba,
   output logic [LBA_W-1:0]         stripe,
   output logic [$clog2(NDISK)-1:0] pdisk,
   output logic [$clog2(NDISK)-1:0] ddisk
);
   localparam int  DISK_W    = $clog2(NDISK);
   localparam int  NDATA     = NDISK - 1;
   localparam int  SLOT_W    = (NDATA > 1) ? $clog2(NDATA) : 1;
   localparam bit  SLOT_POW2 = ((1 << SLOT_W) == NDATA);

   logic [SLOT_W-1:0] slot;
   logic [DISK_W-1:0] rot;
   logic [DISK_W-1:0] slot_x;

   // block number -> stripe and slot; shift when the data width is a power of two
   generate
      if (SLOT_POW2) begin : g_shift
         assign stripe = lba >> SLOT_W;
         assign slot   = lba[SLOT_W-1:0];
      end else begin : g_div
         assign stripe = lba / LBA_W'(NDATA);
         assign slot   = SLOT_W'(lba % LBA_W'(NDATA));
      end
   endgenerate

   // parity walks down one column per stripe, starting at the last column
   assign rot    = DISK_W'(stripe % LBA_W'(NDISK));
   assign pdisk  = DISK_W'(NDISK - 1) - rot;

   // data slots skip over the parity column
   assign slot_x = DISK_W'(slot);
   assign ddisk  = (slot_x >= pdisk) ? slot_x + DISK_W'(1) : slot_x;

endmodule

// File: rtl/raid5_rmw_parity.sv
module raid5_rmw_parity #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seed_en,
   input  logic              fold_en,
   input  logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] new_data,
   output logic [DATA_W-1:0] acc
);
   // seed: old data ^ new data; fold: xor in old parity
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (seed_en)
         acc <= rdata ^ new_data;
      else if (fold_en)
         acc <= acc ^ rdata;
   end

   // R5: the fold must never coincide with a seed
   assert_seed_fold_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(seed_en && fold_en));

endmodule

// File: rtl/raid5_rmw_seq.sv
module raid5_rmw_seq
   import raid5_rmw_pkg::*;
#(
   parameter int LBA_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [LBA_W-1:0]  req_lba,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              resp_valid,
   input  logic [DATA_W-1:0] resp_rdata,
   output logic              busy,
   output logic              done,
   output logic              issue,
   output logic              op_write,
   output logic              use_par,
   output logic              seed_en,
   output logic              fold_en,
   output logic [LBA_W-1:0]  cur_lba,
   output logic [DATA_W-1:0] cur_wdata,
   output logic [DATA_W-1:0] rd_data
);
   eng_state_t state, nstate;
   logic       cur_wr;

   always_comb begin
      nstate = state;
      unique case (state)
         ST_IDLE:      if (req_valid)  nstate = ST_RD_DAT;
         ST_RD_DAT:                    nstate = ST_WT_RD_DAT;
         ST_WT_RD_DAT: if (resp_valid) nstate = cur_wr ? ST_RD_PAR : ST_DONE;
         ST_RD_PAR:                    nstate = ST_WT_RD_PAR;
         ST_WT_RD_PAR: if (resp_valid) nstate = ST_WR_DAT;
         ST_WR_DAT:                    nstate = ST_WT_WR_DAT;
         ST_WT_WR_DAT: if (resp_valid) nstate = ST_WR_PAR;
         ST_WR_PAR:                    nstate = ST_WT_WR_PAR;
         ST_WT_WR_PAR: if (resp_valid) nstate = ST_DONE;
         ST_DONE:                      nstate = ST_IDLE;
         default:                      nstate = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_IDLE;
      else
         state <= nstate;
   end

   // request capture happens only from idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_wr    <= 1'b0;
         cur_lba   <= '0;
         cur_wdata <= '0;
      end else if (state == ST_IDLE && req_valid) begin
         cur_wr    <= req_write;
         cur_lba   <= req_lba;
         cur_wdata <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (state == ST_WT_RD_DAT && resp_valid && !cur_wr)
         rd_data <= resp_rdata;
   end

   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_DONE);
   assign issue    = is_issue_state(state);
   assign op_write = (state == ST_WR_DAT) || (state == ST_WR_PAR);
   assign use_par  = (state == ST_RD_PAR) || (state == ST_WR_PAR);
   assign seed_en  = (state == ST_WT_RD_DAT) && resp_valid && cur_wr;
   assign fold_en  = (state == ST_WT_RD_PAR) && resp_valid;

   assert_issue_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> !issue);
   assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> (busy && issue));
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
   assert_done_after_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(resp_valid));
   assert_write_only_for_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op_write) |-> cur_wr);

endmodule

// File: rtl/raid5_rmw_engine.sv
module raid5_rmw_engine #(
   parameter int NDISK  = 5,
   parameter int LBA_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic [LBA_W-1:0]         req_lba,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     busy,
   output logic                     done,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     dreq_valid,
   output logic                     dreq_write,
   output logic [$clog2(NDISK)-1:0] dreq_disk,
   output logic [LBA_W-1:0]         dreq_stripe,
   output logic [DATA_W-1:0]        dreq_wdata,
   input  logic                     dresp_valid,
   input  logic [DATA_W-1:0]        dresp_rdata
);
   localparam int DISK_W = $clog2(NDISK);

   generate
      if (NDISK < 3) begin : g_bad_ndisk
         $error("raid5_rmw_engine: NDISK must be at least 3");
      end
      if (LBA_W < 2 || DATA_W < 1) begin : g_bad_width
         $error("raid5_rmw_engine: LBA_W and DATA_W too small");
      end
   endgenerate

   logic              use_par, op_write, seed_en, fold_en;
   logic [LBA_W-1:0]  cur_lba;
   logic [DATA_W-1:0] cur_wdata, acc;
   logic [DISK_W-1:0] pdisk, ddisk;
   logic [LBA_W-1:0]  stripe;

   raid5_rmw_seq #(.LBA_W(LBA_W), .DATA_W(DATA_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_lba    (req_lba),
      .req_wdata  (req_wdata),
      .resp_valid (dresp_valid),
      .resp_rdata (dresp_rdata),
      .busy       (busy),
      .done       (done),
      .issue      (dreq_valid),
      .op_write   (op_write),
      .use_par    (use_par),
      .seed_en    (seed_en),
      .fold_en    (fold_en),
      .cur_lba    (cur_lba),
      .cur_wdata  (cur_wdata),
      .rd_data    (rd_data)
   );

   raid5_rmw_map #(.NDISK(NDISK), .LBA_W(LBA_W)) u_map (
      .lba    (cur_lba),
      .stripe (stripe),
      .pdisk  (pdisk),
      .ddisk  (ddisk)
   );

   raid5_rmw_parity #(.DATA_W(DATA_W)) u_par (
      .clk      (clk),
      .rst_n    (rst_n),
      .seed_en  (seed_en),
      .fold_en  (fold_en),
      .rdata    (dresp_rdata),
      .new_data (cur_wdata),
      .acc      (acc)
   );

   assign dreq_write  = op_write;
   assign dreq_disk   = use_par ? pdisk : ddisk;
   assign dreq_stripe = stripe;
   assign dreq_wdata  = use_par ? acc : cur_wdata;

   // R3: every issued column lies inside the array
   assert_disk_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dreq_valid |-> (dreq_disk < DISK_W'(NDISK)));
   // R9: no new issue in the cycle a response arrives
   assert_no_issue_on_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dresp_valid |-> !dreq_valid);

endmodule

// File: tb/sim_raid5_rmw_engine.sv
`timescale 1ns/1ps
module sim_raid5_rmw_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_lba = '0;
   logic [31:0] req_wdata = '0;
   logic        busy, done, dreq_valid, dreq_write;
   logic [31:0] rd_data, dreq_wdata;
   logic [2:0]  dreq_disk;
   logic [15:0] dreq_stripe;
   logic        dresp_valid = 1'b0;
   logic [31:0] dresp_rdata = '0;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   raid5_rmw_engine u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_lba(req_lba), .req_wdata(req_wdata), .busy(busy), .done(done),
      .rd_data(rd_data), .dreq_valid(dreq_valid), .dreq_write(dreq_write),
      .dreq_disk(dreq_disk), .dreq_stripe(dreq_stripe), .dreq_wdata(dreq_wdata),
      .dresp_valid(dresp_valid), .dresp_rdata(dresp_rdata));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural array model ----------------
   logic [31:0] mem [int];

   function automatic int par_of(int s);
      return 4 - (s % 5);
   endfunction

   function automatic int data_of(int lba);
      int s = lba / 4, k = lba % 4, p, n = 0;
      p = par_of(s);
      for (int d = 0; d < 5; d++) begin
         if (d != p) begin
            if (n == k) return d;
            n++;
         end
      end
      return -1;
   endfunction

   function automatic logic [31:0] seedv(int d, int s);
      return 32'h5A5A0000 ^ 32'(s * 1103) ^ 32'(d * 40503) ^ (32'(d) << 28);
   endfunction

   function automatic logic [31:0] memget(int d, int s);
      logic [31:0] x = '0;
      int k = s * 8 + d;
      if (mem.exists(k)) return mem[k];
      if (d != par_of(s)) return seedv(d, s);
      for (int e = 0; e < 5; e++) if (e != d) x ^= seedv(e, s);
      return x;
   endfunction

   int          q_disk[$], q_strp[$];
   bit          q_wr[$];
   logic [31:0] q_dat[$];
   string       q_tag[$];
   logic [31:0] exp_rd = '0;
   bit          cur_is_read = 0;

   task automatic plan_request(input bit wr, input int lba, input logic [31:0] nd);
      int s = lba / 4;
      int p = par_of(s);
      int dd = data_of(lba);
      logic [31:0] od, op;
      if (!wr) begin
         cur_is_read = 1;
         exp_rd = memget(dd, s);
         q_disk.push_back(dd); q_strp.push_back(s); q_wr.push_back(0); q_dat.push_back('0); q_tag.push_back("R6");
      end else begin
         cur_is_read = 0;
         od = memget(dd, s);
         op = memget(p, s);
         q_disk.push_back(dd); q_strp.push_back(s); q_wr.push_back(0); q_dat.push_back('0);     q_tag.push_back("R3");
         q_disk.push_back(p);  q_strp.push_back(s); q_wr.push_back(0); q_dat.push_back('0);     q_tag.push_back("R2");
         q_disk.push_back(dd); q_strp.push_back(s); q_wr.push_back(1); q_dat.push_back(nd);     q_tag.push_back("R3");
         q_disk.push_back(p);  q_strp.push_back(s); q_wr.push_back(1); q_dat.push_back(od ^ nd ^ op); q_tag.push_back("R2");
      end
   endtask

   // ---------------- per-cycle monitor and disk responder ----------------
   bit          exp_busy = 0, prev_done = 0, done_due = 0, exp_done, outstanding = 0;
   int          resp_cnt = 0, opn = 0;
   logic [31:0] resp_word = '0;

   initial begin
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         exp_done = done_due;
         done_due = 0;
         dresp_valid = 1'b0;
         if (req_valid && !exp_busy) begin
            exp_busy = 1;
            plan_request(req_write, int'(req_lba), req_wdata);
         end else if (prev_done) begin
            exp_busy = 0;
         end
         chk(busy === exp_busy, "R8 busy", 32'(busy), 32'(exp_busy));
         chk(done === exp_done, "R7 done", 32'(done), 32'(exp_done));
         if (done && cur_is_read) chk(rd_data === exp_rd, "R6 rd_data", rd_data, exp_rd);
         if (done) chk(q_disk.size() == 0, "R4 op count", 32'(q_disk.size()), 0);
         prev_done = done;
         if (resp_cnt > 0) begin
            resp_cnt--;
            if (resp_cnt == 0) begin
               dresp_valid = 1'b1;
               dresp_rdata = resp_word;
               outstanding = 0;
               if (q_disk.size() == 0) done_due = 1;
            end
         end
         if (dreq_valid) begin
            chk(!outstanding, "R9 issue while waiting", 1, 0);
            if (q_disk.size() == 0) begin
               chk(0, "R8 unexpected disk op", 32'(dreq_disk), 32'hFFFFFFFF);
            end else begin
               chk(int'(dreq_disk) == q_disk[0], q_tag[0], 32'(dreq_disk), 32'(q_disk[0]));
               chk(int'(dreq_stripe) == q_strp[0], "R1 stripe", 32'(dreq_stripe), 32'(q_strp[0]));
               chk(dreq_write === q_wr[0], "R4 op order", 32'(dreq_write), 32'(q_wr[0]));
               if (q_wr[0]) chk(dreq_wdata === q_dat[0], "R5 write data", dreq_wdata, q_dat[0]);
               void'(q_disk.pop_front()); void'(q_strp.pop_front()); void'(q_wr.pop_front());
               void'(q_dat.pop_front());  void'(q_tag.pop_front());
            end
            if (dreq_write) mem[int'(dreq_stripe) * 8 + int'(dreq_disk)] = dreq_wdata;
            else resp_word = memget(int'(dreq_disk), int'(dreq_stripe));
            outstanding = 1;
            resp_cnt = 1 + (opn % 3);
            opn++;
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic issue(input bit wr, input int lba, input logic [31:0] d, input bit noise);
      @(negedge clk);
      while (busy || req_valid) @(negedge clk);
      #1 req_valid = 1'b1; req_write = wr; req_lba = 16'(lba); req_wdata = d;
      @(negedge clk);
      #1 req_valid = 1'b0;
      if (noise) begin
         @(negedge clk);
         #1 req_valid = 1'b1; req_write = 1'b1; req_lba = 16'h1234; req_wdata = 32'hDEADBEEF;
         @(negedge clk);
         #1 req_valid = 1'b0;
      end
   endtask

   task automatic report;
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy === 1'b0, "R10 busy in reset", 32'(busy), 0);
      chk(done === 1'b0, "R10 done in reset", 32'(done), 0);
      chk(dreq_valid === 1'b0, "R10 dreq in reset", 32'(dreq_valid), 0);
      #1 rst_n = 1'b1;
      // plain reads across stripes with different parity columns
      issue(0, 0, '0, 0);
      issue(0, 3, '0, 0);
      issue(0, 7, '0, 0);
      issue(0, 18, '0, 0);
      // writes covering every slot of five stripes (all parity positions)
      for (int b = 0; b < 20; b++) issue(1, b, 32'hC0DE0000 + 32'(b * 77), (b % 6) == 1);
      // second stripe round, parity back on the last column
      issue(1, 21, 32'h0BADF00D, 0);
      // read back freshly written blocks
      issue(0, 5, '0, 0);
      issue(0, 19, '0, 0);
      issue(0, 21, '0, 0);
      // largest block number
      issue(1, 65535, 32'hFFFF0001, 1);
      issue(0, 65535, '0, 0);
      // overwrite the same block twice in a row
      issue(1, 9, 32'h11111111, 0);
      issue(1, 9, 32'h22222222, 0);
      issue(0, 9, '0, 0);
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(q_disk.size() == 0, "R4 leftover ops", 32'(q_disk.size()), 0);
      for (int s = 0; s < 7; s++) begin
         logic [31:0] x = '0;
         for (int d = 0; d < 5; d++) x ^= memget(d, s);
         chk(x == '0, "R5 stripe parity", x, 0);
      end
      begin
         logic [31:0] x = '0;
         for (int d = 0; d < 5; d++) x ^= memget(d, 16383);
         chk(x == '0, "R5 top stripe parity", x, 0);
      end
      report();
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      report();
   end

endmodule